// File: doc/BRIEF.md
# Peripheral Clock-Stop Register Bank

This block holds one stop bit per peripheral in a small byte-wide register bank: one general register for system-level peripherals, two registers for analog ports and four registers for digital ports. Each stop bit turns into a clock enable for its peripheral. A stopped peripheral keeps all of its internal state because its clock simply no longer ticks, and it carries on from that state once its bit is cleared. Every enable is also ANDed with a domain enable from the sleep controller, so the stop bits only matter while that domain clock is running (active and idle operation).

The block also guards the peripheral register bus. A read aimed at a stopped peripheral returns 0x00 in place of the peripheral's data. A write aimed at a stopped peripheral is not forwarded, and it raises a one-cycle access-error flag. A one-bit state machine drives this flag. Its states are `ERR_CLEAR` (no flag) and `ERR_RAISED` (flag high). On each clock edge it moves to `ERR_RAISED` if a blocked write is present in that cycle, and otherwise to `ERR_CLEAR`.

Peripherals are numbered in one flat vector. Indices 0–4 are the general bits. Indices 5–10 are the analog ports, three per port. Indices 11–38 are the digital ports, seven per port. Within each group the numbering follows register offset first and bit number second.

Top module: `clkgate_bank`

## Requirements
- R1: After reset every stop bit is 0. Every register reads 0x00, every `clk_en` bit is 1 while `domain_en` is 1, and every `access_ok` bit is 1.
- R2: Offset 0 (general) implements bits 0..4: 0 DMA, 1 event routing, 2 real-time counter, 3 external memory bus, 4 AES. Bits 7..5 read 0 and ignore writes.
- R3: Offsets 1 and 2 (analog ports) implement bits 0..2: 0 comparator, 1 ADC, 2 DAC. Bits 7..3 read 0.
- R4: Offsets 3..6 (digital ports) implement bits 0..6: 0 timer 0, 1 timer 1, 2 high-resolution extension, 3 SPI, 4 UART 0, 5 UART 1, 6 I2C. Bit 7 reads 0.
- R5: Offset 7 is reserved. It reads 0x00, and a write to it changes no stop bit.
- R6: Flat peripheral index is i for offset 0 bit i, 5+3·(off−1)+b for analog offsets, and 11+7·(off−3)+b for digital offsets.
- R7: `clk_en[i]` equals NOT stop[i] AND `domain_en`. With `domain_en` low every enable is 0, and the register contents are kept.
- R8: A register write changes `clk_en` and `access_ok` only from the rising edge that captures it. Without a write and with `domain_en` steady, `clk_en` does not change.
- R9: `access_ok[i]` is NOT stop[i]. A read (`pbus_req`=1, `pbus_wr`=0) of a stopped peripheral returns 0x00 on `pbus_rdata`. A read of a running peripheral returns `pbus_rdata_in` in the same cycle.
- R10: A write (`pbus_req`=1, `pbus_wr`=1) to a stopped peripheral keeps `pbus_wr_ok` at 0, and it sets `acc_err` to 1 for exactly the following cycle. A write to a running peripheral sets `pbus_wr_ok` to 1 and raises no error.
- R11: A `pbus_sel` value of 39 or more returns 0x00, forwards no write and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| domain_en | input | 1 | Peripheral clock-domain enable from the sleep controller |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data (combinational) |
| pbus_req | input | 1 | Peripheral bus access request |
| pbus_wr | input | 1 | Access is a write |
| pbus_sel | input | 6 | Flat index of the target peripheral |
| pbus_rdata_in | input | 8 | Read data from the selected peripheral |
| pbus_rdata | output | 8 | Filtered read data |
| pbus_wr_ok | output | 1 | Write forwarded to the peripheral |
| access_ok | output | 39 | Per-peripheral access-valid |
| clk_en | output | 39 | Per-peripheral clock enable |
| acc_err | output | 1 | One-cycle flag after a blocked write |

## Verification
Register reads and the bus filter outputs (`pbus_rdata`, `pbus_wr_ok`) are combinational, so they are due in the same cycle as their stimulus. New stop bits reach `clk_en` and `access_ok` after the one rising edge that captures the write. `acc_err` goes high one edge after the blocked write and falls on the edge after that. The bench drives inputs on falling edges and samples on the next falling edge, or a short delay after driving for combinational paths. In addition, just before the capturing edge it checks that a pending write has not yet changed `clk_en`.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    parameter int REG_W    = 8;
    parameter int GEN_BITS = 5;
    parameter int ANA_BITS = 3;
    parameter int DIG_BITS = 7;
    parameter int NUM_ANA  = 2;
    parameter int NUM_DIG  = 4;

    localparam int NUM_REGS   = 1 + NUM_ANA + NUM_DIG;
    localparam int ADDR_W     = $clog2(NUM_REGS + 1);
    localparam int NUM_PERIPH = GEN_BITS + NUM_ANA * ANA_BITS + NUM_DIG * DIG_BITS;
    localparam int SEL_W      = $clog2(NUM_PERIPH);
    localparam int SEL_SPAN   = 2 ** SEL_W;

    typedef enum logic {
        ERR_CLEAR  = 1'b0,
        ERR_RAISED = 1'b1
    } err_state_e;

    function automatic int reg_width(input int r);
        if (r == 0)              return GEN_BITS;
        else if (r <= NUM_ANA)   return ANA_BITS;
        else if (r < NUM_REGS)   return DIG_BITS;
        else                     return 0;
    endfunction

    function automatic int reg_base(input int r);
        if (r == 0)              return 0;
        else if (r <= NUM_ANA)   return GEN_BITS + (r - 1) * ANA_BITS;
        else                     return GEN_BITS + NUM_ANA * ANA_BITS + (r - 1 - NUM_ANA) * DIG_BITS;
    endfunction

    function automatic logic [REG_W-1:0] reg_mask(input int r);
        return REG_W'((1 << reg_width(r)) - 1);
    endfunction
endpackage

// File: rtl/clkgate_regfile.sv
module clkgate_regfile
    import clkgate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_W-1:0]      wdata,
    input  logic                  we,
    output logic [REG_W-1:0]      rdata,
    output logic [NUM_PERIPH-1:0] stop_flat
);
    logic [REG_W-1:0] reg_q [NUM_REGS];
    logic             hit;

    assign hit = (32'(addr) < NUM_REGS);

    // Only implemented bits are ever stored; the rest stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) reg_q[r] <= '0;
        end else if (we && hit) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (32'(addr) == r) reg_q[r] <= wdata & reg_mask(r);
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (hit && (32'(addr) == r)) rdata = reg_q[r];
        end
    end

    // Flatten implemented bits into the peripheral index space.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar b = 0; b < REG_W; b++) begin : g_bit
            if (b < reg_width(r)) begin : g_used
                assign stop_flat[reg_base(r) + b] = reg_q[r][b];
            end
        end
    end
endmodule

// File: rtl/clkgate_enables.sv
module clkgate_enables
    import clkgate_pkg::*;
(
    input  logic                  domain_en,
    input  logic [NUM_PERIPH-1:0] stop_flat,
    output logic [NUM_PERIPH-1:0] clk_en,
    output logic [NUM_PERIPH-1:0] access_ok
);
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_en
        assign clk_en[i]    = domain_en & ~stop_flat[i];
        assign access_ok[i] = ~stop_flat[i];
    end
endmodule

// File: rtl/clkgate_access.sv
module clkgate_access
    import clkgate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] access_ok,
    input  logic                  req,
    input  logic                  wr,
    input  logic [SEL_W-1:0]      sel,
    input  logic [REG_W-1:0]      rdata_in,
    output logic [REG_W-1:0]      rdata_out,
    output logic                  wr_ok,
    output logic                  err
);
    logic [SEL_SPAN-1:0] ok_pad;
    logic                in_range;
    logic                target_ok;
    logic                blocked_wr;
    err_state_e          state_q, state_d;

    assign ok_pad     = SEL_SPAN'(access_ok);
    assign in_range   = (32'(sel) < NUM_PERIPH);
    assign target_ok  = ok_pad[sel];
    assign blocked_wr = req && wr && in_range && !target_ok;

    assign rdata_out = (req && !wr && target_ok) ? rdata_in : '0;
    assign wr_ok     = req && wr && target_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAR:  state_d = blocked_wr ? ERR_RAISED : ERR_CLEAR;
            ERR_RAISED: state_d = blocked_wr ? ERR_RAISED : ERR_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ERR_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ERR_CLEAR:  err = 1'b0;
            ERR_RAISED: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank
    import clkgate_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  domain_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    input  logic                  reg_we,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  pbus_req,
    input  logic                  pbus_wr,
    input  logic [SEL_W-1:0]      pbus_sel,
    input  logic [REG_W-1:0]      pbus_rdata_in,
    output logic [REG_W-1:0]      pbus_rdata,
    output logic                  pbus_wr_ok,
    output logic [NUM_PERIPH-1:0] access_ok,
    output logic [NUM_PERIPH-1:0] clk_en,
    output logic                  acc_err
);
    logic [NUM_PERIPH-1:0] stop_flat;

    clkgate_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .we        (reg_we),
        .rdata     (reg_rdata),
        .stop_flat (stop_flat)
    );

    clkgate_enables u_en (
        .domain_en (domain_en),
        .stop_flat (stop_flat),
        .clk_en    (clk_en),
        .access_ok (access_ok)
    );

    clkgate_access u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .access_ok (access_ok),
        .req       (pbus_req),
        .wr        (pbus_wr),
        .sel       (pbus_sel),
        .rdata_in  (pbus_rdata_in),
        .rdata_out (pbus_rdata),
        .wr_ok     (pbus_wr_ok),
        .err       (acc_err)
    );
endmodule

// File: rtl/clkgate_bank_chk.sv
module clkgate_bank_chk
    import clkgate_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  domain_en,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  reg_we,
    input logic [REG_W-1:0]      reg_rdata,
    input logic                  pbus_req,
    input logic                  pbus_wr,
    input logic [SEL_W-1:0]      pbus_sel,
    input logic [REG_W-1:0]      pbus_rdata,
    input logic                  pbus_wr_ok,
    input logic [NUM_PERIPH-1:0] access_ok,
    input logic [NUM_PERIPH-1:0] clk_en,
    input logic                  acc_err
);
    logic [SEL_SPAN-1:0] ok_pad;
    logic                sel_in;
    assign ok_pad = SEL_SPAN'(access_ok);
    assign sel_in = (32'(pbus_sel) < NUM_PERIPH);

    a_r7_domain_off: assert property (@(posedge clk) disable iff (!rst_n)
        !domain_en |-> (clk_en == '0));

    a_r7_enable_implies_access: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_en & ~access_ok) == '0));

    a_r8_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(clk_en) || !$stable(domain_en)));

    a_r5_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(NUM_REGS)) |-> (reg_rdata == '0));

    a_r9_blocked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_req && !pbus_wr && !ok_pad[pbus_sel]) |-> (pbus_rdata == '0));

    a_r10_forward_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_wr_ok |-> (pbus_req && pbus_wr && ok_pad[pbus_sel]));

    a_r10_blocked_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_req && pbus_wr && sel_in && !ok_pad[pbus_sel]) |=> acc_err);

    a_r11_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!pbus_req || !pbus_wr || !sel_in || ok_pad[pbus_sel]) |=> !acc_err);
endmodule

bind clkgate_bank clkgate_bank_chk u_chk (.*);

// File: tb/tb_clkgate_bank.sv
`timescale 1ns/1ps
module tb_clkgate_bank;
    localparam int NP = 39;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          domain_en = 1'b1;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_rdata;
    logic          pbus_req = 1'b0;
    logic          pbus_wr = 1'b0;
    logic [5:0]    pbus_sel = '0;
    logic [7:0]    pbus_rdata_in = '0;
    logic [7:0]    pbus_rdata;
    logic          pbus_wr_ok;
    logic [NP-1:0] access_ok;
    logic [NP-1:0] clk_en;
    logic          acc_err;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] mdl [8];

    always #2 clk = ~clk;

    clkgate_bank dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_mask(input int off);
        if (off == 0)      return 8'h1F;
        else if (off <= 2) return 8'h07;
        else if (off <= 6) return 8'h7F;
        else               return 8'h00;
    endfunction

    function automatic logic [NP-1:0] exp_stop();
        logic [NP-1:0] v = '0;
        for (int i = 0; i < NP; i++) begin
            int off, b;
            if (i < 5)       begin off = 0;                b = i;            end
            else if (i < 11) begin off = 1 + (i - 5) / 3;  b = (i - 5) % 3;  end
            else             begin off = 3 + (i - 11) / 7; b = (i - 11) % 7; end
            v[i] = mdl[off][b];
        end
        return v;
    endfunction

    task automatic wr_reg(input int off, input logic [7:0] d);
        @(negedge clk);
        reg_addr = 3'(off); reg_wdata = d; reg_we = 1'b1;
        mdl[off] = d & exp_mask(off);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic stop_only(input int i);
        for (int o = 0; o < 7; o++) if (mdl[o] != 8'h00) wr_reg(o, 8'h00);
        if (i < 5)       wr_reg(0, 8'(1 << i));
        else if (i < 11) wr_reg(1 + (i - 5) / 3, 8'(1 << ((i - 5) % 3)));
        else             wr_reg(3 + (i - 11) / 7, 8'(1 << ((i - 11) % 7)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int o = 0; o < 8; o++) mdl[o] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int o = 0; o < 8; o++) begin
            reg_addr = 3'(o); #0.5;
            chk(reg_rdata == 8'h00, "R1", "reset read", 64'(reg_rdata), 0);
        end
        chk(clk_en == {NP{1'b1}}, "R1", "reset clk_en", 64'(clk_en), 64'({NP{1'b1}}));
        chk(access_ok == {NP{1'b1}}, "R1", "reset access_ok", 64'(access_ok), 64'({NP{1'b1}}));

        // R2 R3 R4 R5: implemented bit masks per offset
        for (int o = 0; o < 8; o++) begin
            wr_reg(o, 8'hFF);
            reg_addr = 3'(o); #0.5;
            chk(reg_rdata == exp_mask(o), (o == 0) ? "R2" : (o <= 2) ? "R3" : (o <= 6) ? "R4" : "R5",
                "mask readback", 64'(reg_rdata), 64'(exp_mask(o)));
            chk(clk_en == ~exp_stop(), "R6", "clk_en after all-ones", 64'(clk_en), 64'(~exp_stop()));
            wr_reg(o, 8'h00);
        end

        // R6: walking single bit sweep
        for (int o = 0; o < 8; o++) begin
            for (int b = 0; b < 8; b++) begin
                wr_reg(o, 8'(1 << b));
                chk(clk_en == ~exp_stop(), "R6", "walking clk_en", 64'(clk_en), 64'(~exp_stop()));
                chk(access_ok == ~exp_stop(), "R9", "walking access_ok", 64'(access_ok), 64'(~exp_stop()));
            end
            wr_reg(o, 8'h00);
        end
        wr_reg(7, 8'hFF);
        chk(clk_en == {NP{1'b1}}, "R5", "reserved write no effect", 64'(clk_en), 64'({NP{1'b1}}));

        // R8: nothing changes before the capturing edge
        @(negedge clk);
        reg_addr = 3'd4; reg_wdata = 8'h2A; reg_we = 1'b1; mdl[4] = 8'h2A;
        #0.5;
        chk(clk_en == {NP{1'b1}}, "R8", "before edge", 64'(clk_en), 64'({NP{1'b1}}));
        @(negedge clk);
        reg_we = 1'b0;
        chk(clk_en == ~exp_stop(), "R8", "after edge", 64'(clk_en), 64'(~exp_stop()));
        @(negedge clk);
        chk(clk_en == ~exp_stop(), "R8", "held without write", 64'(clk_en), 64'(~exp_stop()));

        // R7: domain gate
        wr_reg(0, 8'h13);
        domain_en = 1'b0; #0.5;
        chk(clk_en == '0, "R7", "domain off", 64'(clk_en), 0);
        reg_addr = 3'd0; #0.5;
        chk(reg_rdata == 8'h13, "R7", "contents kept", 64'(reg_rdata), 64'h13);
        @(negedge clk);
        domain_en = 1'b1; #0.5;
        chk(clk_en == ~exp_stop(), "R7", "domain back on", 64'(clk_en), 64'(~exp_stop()));

        // R9 R10: per-peripheral access filtering
        for (int i = 0; i < NP; i++) begin
            int other;
            other = (i + 17) % NP;
            stop_only(i);
            @(negedge clk);
            pbus_req = 1'b1; pbus_wr = 1'b0; pbus_sel = 6'(i); pbus_rdata_in = 8'h5A; #0.5;
            chk(pbus_rdata == 8'h00, "R9", "blocked read", 64'(pbus_rdata), 0);
            pbus_sel = 6'(other); #0.5;
            chk(pbus_rdata == 8'h5A, "R9", "open read", 64'(pbus_rdata), 64'h5A);
            pbus_wr = 1'b1; #0.5;
            chk(pbus_wr_ok == 1'b1, "R10", "open write forwarded", 64'(pbus_wr_ok), 1);
            pbus_sel = 6'(i); #0.5;
            chk(pbus_wr_ok == 1'b0, "R10", "blocked write held", 64'(pbus_wr_ok), 0);
            @(negedge clk);
            pbus_req = 1'b0; pbus_wr = 1'b0;
            chk(acc_err == 1'b1, "R10", "error raised", 64'(acc_err), 1);
            @(negedge clk);
            chk(acc_err == 1'b0, "R10", "error one cycle", 64'(acc_err), 0);
        end

        // R10: write to a running peripheral raises no error
        @(negedge clk);
        pbus_req = 1'b1; pbus_wr = 1'b1; pbus_sel = 6'd0;
        @(negedge clk);
        pbus_req = 1'b0;
        chk(acc_err == 1'b0, "R10", "no error on open write", 64'(acc_err), 0);

        // R11: out-of-range selects
        for (int s = NP; s < 64; s += 6) begin
            @(negedge clk);
            pbus_req = 1'b1; pbus_wr = 1'b0; pbus_sel = 6'(s); pbus_rdata_in = 8'hC3; #0.5;
            chk(pbus_rdata == 8'h00, "R11", "range read", 64'(pbus_rdata), 0);
            pbus_wr = 1'b1; #0.5;
            chk(pbus_wr_ok == 1'b0, "R11", "range write", 64'(pbus_wr_ok), 0);
            @(negedge clk);
            pbus_req = 1'b0; pbus_wr = 1'b0;
            chk(acc_err == 1'b0, "R11", "range no error", 64'(acc_err), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule